// File: doc/BRIEF.md
# Line-Synchronized Rectified Sine Reference

This block produces the current-loop reference for a boost power-factor stage. The reference shape comes from a computed rectified-sine table, never from the sensed line voltage. A phase accumulator steps the table once per sample strobe and restarts at every line zero-crossing pulse, so one sweep of the table spans one mains half-cycle. Each table value is multiplied by the voltage-loop amplitude command and a fixed scaling gain. The result is saturated at 1.0, which stands for maximum input current.

The half-cycle length is measured in sample strobes between consecutive zero-crossing pulses. A reciprocal divider turns that length into the phase step. The amplitude command is captured only when a half-cycle begins, so the gain stays constant for a whole half-cycle. If the line pulse goes missing, the block starts half-cycles on its own from the last measured period and raises a sync-lost flag.

A period-tracking machine decides where half-cycles begin. It has three states:
- `TRK_ACQUIRE` (after reset): moves to `TRK_LOCKED` on a pulse, or to `TRK_FREERUN` on a timeout.
- `TRK_LOCKED`: stays there on a pulse, which re-measures the period, and moves to `TRK_FREERUN` on a timeout.
- `TRK_FREERUN`: returns to `TRK_LOCKED` on a pulse.

The reciprocal divider has its own machine: `DIV_IDLE` goes to `DIV_SHIFT` on start, `DIV_SHIFT` goes to `DIV_FINISH` after the last quotient bit, and `DIV_FINISH` goes back to `DIV_IDLE`. A new start in any state goes to `DIV_SHIFT`.

Top module: `line_sine_ref`

## Requirements
- R1: After reset `ref_out` is 0, `ref_vld` is 0 and `sync_lost` is 0. The held amplitude is 0, so every sample before the first half-cycle boundary gives a reference of 0.
- R2: A sample strobe in cycle n makes `ref_vld` high for exactly one cycle, in cycle n+2. `ref_vld` is low otherwise.
- R3: Table entry i (0..2^TBL_AW-1, with N = 2^TBL_AW) equals floor((2^(OUT_W-1)-1)·16·x / (5·N² − 4·x)), where x = i·(N−i).
- R4: The table index is the top TBL_AW bits of a PH_W-bit phase. The phase returns to 0 at each half-cycle boundary and advances by the step after each strobe. A strobe in the same cycle as a boundary reads index 0 and leaves the phase equal to the step.
- R5: The step is floor(2^PH_W / P), limited to 2^PH_W−1. P starts at NOM_PER. The new step applies to strobes that come at least PH_W+4 cycles after the pulse.
- R6: When a boundary occurs in `TRK_LOCKED`, P is set to the number of strobes counted since the previous boundary (at least 1, at most 2^CNT_W−1).
- R7: The amplitude is taken from `amp_cmd` only at a half-cycle boundary. A change of `amp_cmd` between boundaries does not alter the reference.
- R8: `amp_cmd` is signed, with 1.0 = 2^(CMD_W-2). Negative values are used as 0 and values above 1.0 are used as 1.0.
- R9: `ref_out` equals floor(table·amp·GAIN / 2^(CMD_W-2+GAIN_FRAC)), limited to 2^(OUT_W-1) (1.0). The default GAIN/2^GAIN_FRAC is 3.0.
- R10: If a step would carry the phase past 2^PH_W−1, the phase holds at 2^PH_W−1, so the index stays at its last entry.
- R11: Suppose P + floor(P/2) strobes have been counted since the last boundary in `TRK_ACQUIRE` or `TRK_LOCKED`, with no pulse. The next strobe then starts a half-cycle, and `sync_lost` rises.
- R12: In `TRK_FREERUN` a boundary occurs on every P-th strobe, and P is not re-measured.
- R13: A zero-crossing pulse clears `sync_lost` on the next cycle. The first pulse after reset or after `TRK_FREERUN` does not update P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| zc_pulse | input | 1 | One-cycle line zero-crossing pulse |
| smp_stb | input | 1 | One-cycle sample strobe |
| amp_cmd | input | CMD_W | Signed amplitude command from the voltage loop, 1.0 = 2^(CMD_W-2) |
| ref_out | output | OUT_W | Unsigned reference, 1.0 = 2^(OUT_W-1) |
| ref_vld | output | 1 | High for one cycle when a new reference is on `ref_out` |
| sync_lost | output | 1 | High while half-cycles are generated without line pulses |

## Verification
The bench builds the block with CNT_W = 8, NOM_PER = 20 and PH_W = 16, leaving the table and gain at their defaults. A nominal half-cycle of 20 strobes, with a timeout at 30, makes the missing-pulse timeout and several free-running half-cycles reachable within a few hundred strobes. It also makes phase saturation appear after only a few overrun strobes. Period changes from 20 to 25, 32 and 10 strobes exercise the reciprocal divider over several quotients, and small table indices show whether an out-of-range command was clamped.

// File: rtl/line_sine_ref_pkg.sv
package line_sine_ref_pkg;

    typedef longint unsigned u64_t;

    typedef enum logic [1:0] {
        TRK_ACQUIRE,
        TRK_LOCKED,
        TRK_FREERUN
    } trk_state_t;

    typedef enum logic [1:0] {
        DIV_IDLE,
        DIV_SHIFT,
        DIV_FINISH
    } div_state_t;

    // Half-wave sine magnitude for entry idx of an n-entry table, vbits wide,
    // using a rational approximation that needs only integer arithmetic.
    function automatic u64_t sine_entry(input int unsigned idx,
                                        input int unsigned n,
                                        input int unsigned vbits);
        u64_t x;
        u64_t full;
        x    = u64_t'(idx) * u64_t'(n - idx);
        full = (u64_t'(1) << vbits) - u64_t'(1);
        return (full * 64'd16 * x) / (64'd5 * u64_t'(n) * u64_t'(n) - 64'd4 * x);
    endfunction

endpackage

// File: rtl/lsr_sine_rom.sv
module lsr_sine_rom
    import line_sine_ref_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int VAL_W = 15
) (
    input  logic [IDX_W-1:0] idx,
    output logic [VAL_W-1:0] val
);
    localparam int DEPTH = 1 << IDX_W;

    logic [VAL_W-1:0] rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        localparam u64_t ENT = sine_entry(g, DEPTH, VAL_W);
        assign rom[g] = ENT[VAL_W-1:0];
    end

    assign val = rom[idx];

endmodule

// File: rtl/lsr_recip_div.sv
module lsr_recip_div
    import line_sine_ref_pkg::*;
#(
    parameter int PH_W  = 16,
    parameter int CNT_W = 12,
    parameter logic [PH_W-1:0] INC_RST = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] divisor,
    output logic [PH_W-1:0]  incr
);
    localparam int NBITS = PH_W + 1;
    localparam int SC_W  = $clog2(NBITS + 1);

    div_state_t       state, state_nx;
    logic [CNT_W-1:0] dvs;
    logic [CNT_W:0]   rem;
    logic [CNT_W:0]   rem_sh;
    logic [NBITS-1:0] quo;
    logic [SC_W-1:0]  step;
    logic             qbit;
    logic             last;

    // Dividend is 2^PH_W: a single one in the first bit, zeros after it.
    assign rem_sh = {rem[CNT_W-1:0], (step == '0)};
    assign qbit   = (rem_sh >= {1'b0, dvs});
    assign last   = (step == SC_W'(NBITS - 1));

    always_comb begin
        state_nx = state;
        unique case (state)
            DIV_IDLE:   if (start) state_nx = DIV_SHIFT;
            DIV_SHIFT:  if (start) state_nx = DIV_SHIFT;
                        else if (last) state_nx = DIV_FINISH;
            DIV_FINISH: state_nx = start ? DIV_SHIFT : DIV_IDLE;
            default:    state_nx = DIV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= DIV_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dvs  <= '0;
            rem  <= '0;
            quo  <= '0;
            step <= '0;
            incr <= INC_RST;
        end else if (start) begin
            dvs  <= divisor;
            rem  <= '0;
            quo  <= '0;
            step <= '0;
        end else begin
            unique case (state)
                DIV_SHIFT: begin
                    rem  <= qbit ? (rem_sh - {1'b0, dvs}) : rem_sh;
                    quo  <= {quo[NBITS-2:0], qbit};
                    step <= step + 1'b1;
                end
                DIV_FINISH: incr <= quo[NBITS-1] ? '1 : quo[PH_W-1:0];
                default: ;
            endcase
        end
    end

    // R5: the step register only moves on the cycle after the division ends
    a_r5_step_moves_after_finish: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(incr) |-> $past(state == DIV_FINISH));

    // R5: the partial remainder stays below the divisor while shifting
    a_r5_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DIV_SHIFT && dvs != '0) |-> (rem < {1'b0, dvs}));

endmodule

// File: rtl/lsr_period_track.sv
module lsr_period_track
    import line_sine_ref_pkg::*;
#(
    parameter int CNT_W   = 12,
    parameter int NOM_PER = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             zc,
    input  logic             stb,
    output logic             boundary,
    output logic [CNT_W-1:0] per,
    output logic             per_new,
    output logic             sync_lost
);
    trk_state_t     state, state_nx;
    logic [CNT_W:0] cnt;
    logic [CNT_W:0] limit;
    logic           timeout;

    always_comb begin
        unique case (state)
            TRK_FREERUN: limit = {1'b0, per};
            default:     limit = {1'b0, per} + {2'b00, per[CNT_W-1:1]};
        endcase
    end

    assign timeout  = stb && !zc && (cnt >= limit);
    assign boundary = zc || timeout;

    always_comb begin
        state_nx = state;
        unique case (state)
            TRK_ACQUIRE: if (zc) state_nx = TRK_LOCKED;
                         else if (timeout) state_nx = TRK_FREERUN;
            TRK_LOCKED:  if (timeout) state_nx = TRK_FREERUN;
            TRK_FREERUN: if (zc) state_nx = TRK_LOCKED;
            default:     state_nx = TRK_ACQUIRE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TRK_ACQUIRE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            per     <= CNT_W'(NOM_PER);
            per_new <= 1'b0;
        end else begin
            per_new <= 1'b0;
            if (boundary)  cnt <= stb ? (CNT_W+1)'(1) : '0;
            else if (stb)  cnt <= cnt + 1'b1;
            if (zc && state == TRK_LOCKED) begin
                per     <= (cnt == '0) ? CNT_W'(1) : (cnt[CNT_W] ? '1 : cnt[CNT_W-1:0]);
                per_new <= 1'b1;
            end
        end
    end

    assign sync_lost = (state == TRK_FREERUN);

    // R13: a line pulse always leaves the free-running state
    a_r13_pulse_clears_lost: assert property (@(posedge clk) disable iff (!rst_n)
        zc |=> !sync_lost);

    // R11: loss of sync is only declared on a sample strobe
    a_r11_lost_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_lost) |-> $past(stb));

    // R12: no re-measurement while running without line pulses
    a_r12_no_measure_free: assert property (@(posedge clk) disable iff (!rst_n)
        sync_lost |=> !per_new);

endmodule

// File: rtl/line_sine_ref.sv
module line_sine_ref
    import line_sine_ref_pkg::*;
#(
    parameter int CMD_W     = 16,
    parameter int OUT_W     = 16,
    parameter int PH_W      = 16,
    parameter int TBL_AW    = 8,
    parameter int CNT_W     = 12,
    parameter int NOM_PER   = 100,
    parameter int GAIN_W    = 8,
    parameter int GAIN      = 48,
    parameter int GAIN_FRAC = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    zc_pulse,
    input  logic                    smp_stb,
    input  logic signed [CMD_W-1:0] amp_cmd,
    output logic [OUT_W-1:0]        ref_out,
    output logic                    ref_vld,
    output logic                    sync_lost
);
    localparam int   TBL_W  = OUT_W - 1;
    localparam int   AMP_W  = CMD_W - 1;
    localparam int   PROD_W = TBL_W + AMP_W + GAIN_W;
    localparam int   SHIFT  = CMD_W - 2 + GAIN_FRAC;
    localparam logic [AMP_W-1:0]  AMP_ONE = AMP_W'(1) << (CMD_W - 2);
    localparam logic [OUT_W-1:0]  OUT_ONE = OUT_W'(1) << (OUT_W - 1);
    localparam logic [GAIN_W-1:0] GAIN_V  = GAIN_W'(GAIN);
    localparam u64_t INC0 = (u64_t'(1) << PH_W) / u64_t'(NOM_PER);
    localparam logic [PH_W-1:0] INC_RST = ((INC0 >> PH_W) != 0) ? '1 : INC0[PH_W-1:0];

    logic             boundary;
    logic [CNT_W-1:0] per;
    logic             per_new;
    logic [PH_W-1:0]  incr;
    logic [PH_W-1:0]  phase;
    logic [PH_W-1:0]  phase_use;
    logic [PH_W:0]    phase_sum;
    logic [PH_W-1:0]  phase_adv;
    logic [TBL_W-1:0] tbl_val;
    logic [AMP_W-1:0] amp_clamped;
    logic [AMP_W-1:0] amp_hold;
    logic [AMP_W-1:0] amp_use;
    logic             s1_vld;
    logic [TBL_W-1:0] s1_tbl;
    logic [AMP_W-1:0] s1_amp;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] scaled;
    logic [OUT_W-1:0] sat_val;

    lsr_period_track #(.CNT_W(CNT_W), .NOM_PER(NOM_PER)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .zc        (zc_pulse),
        .stb       (smp_stb),
        .boundary  (boundary),
        .per       (per),
        .per_new   (per_new),
        .sync_lost (sync_lost)
    );

    lsr_recip_div #(.PH_W(PH_W), .CNT_W(CNT_W), .INC_RST(INC_RST)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (per_new),
        .divisor (per),
        .incr    (incr)
    );

    lsr_sine_rom #(.IDX_W(TBL_AW), .VAL_W(TBL_W)) u_rom (
        .idx (phase_use[PH_W-1 -: TBL_AW]),
        .val (tbl_val)
    );

    // Command clamp to the range 0..1.0
    always_comb begin
        if (amp_cmd[CMD_W-1])                  amp_clamped = '0;
        else if (amp_cmd[CMD_W-2:0] > AMP_ONE) amp_clamped = AMP_ONE;
        else                                   amp_clamped = amp_cmd[CMD_W-2:0];
    end

    assign amp_use   = boundary ? amp_clamped : amp_hold;
    assign phase_use = boundary ? '0 : phase;
    assign phase_sum = {1'b0, phase_use} + {1'b0, incr};
    assign phase_adv = phase_sum[PH_W] ? '1 : phase_sum[PH_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase    <= '0;
            amp_hold <= '0;
        end else begin
            if (smp_stb)       phase <= phase_adv;
            else if (boundary) phase <= '0;
            if (boundary)      amp_hold <= amp_clamped;
        end
    end

    // Stage one: table lookup and amplitude capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_vld <= 1'b0;
            s1_tbl <= '0;
            s1_amp <= '0;
        end else begin
            s1_vld <= smp_stb;
            if (smp_stb) begin
                s1_tbl <= tbl_val;
                s1_amp <= amp_use;
            end
        end
    end

    // Stage two: scale, saturate, register
    assign prod    = PROD_W'(s1_tbl) * PROD_W'(s1_amp) * PROD_W'(GAIN_V);
    assign scaled  = prod >> SHIFT;
    assign sat_val = (scaled > PROD_W'(OUT_ONE)) ? OUT_ONE : scaled[OUT_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_out <= '0;
            ref_vld <= 1'b0;
        end else begin
            ref_vld <= s1_vld;
            if (s1_vld) ref_out <= sat_val;
        end
    end

    // R2: every valid pulse traces back to a strobe two cycles earlier
    a_r2_valid_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ref_vld |-> $past(smp_stb, 2));

    // R2: every strobe yields a valid pulse two cycles later
    a_r2_strobe_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |=> ##1 ref_vld);

    // R9: the reference never exceeds 1.0
    a_r9_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        ref_out <= OUT_ONE);

    // R8: the held amplitude stays inside 0..1.0
    a_r8_amp_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        amp_hold <= AMP_ONE);

    // R7: the amplitude is frozen between half-cycle boundaries
    a_r7_amp_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(amp_hold));

    // R4: a pulse without a strobe returns the phase to zero
    a_r4_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (zc_pulse && !smp_stb) |=> (phase == '0));

endmodule

// File: tb/line_sine_ref_test.sv
module line_sine_ref_test;

    localparam int CLK_P = 10;
    localparam int GAP   = 38;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               zc_pulse = 1'b0;
    logic               smp_stb = 1'b0;
    logic signed [15:0] amp_cmd = '0;
    logic [15:0]        ref_out;
    logic               ref_vld;
    logic               sync_lost;

    int checks = 0;
    int fails  = 0;

    // Requirement model state
    int m_phase, m_incr, m_per, m_cnt, m_state, m_amp;

    always #(CLK_P/2) clk = ~clk;

    line_sine_ref #(.PH_W(16), .CNT_W(8), .NOM_PER(20)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .zc_pulse  (zc_pulse),
        .smp_stb   (smp_stb),
        .amp_cmd   (amp_cmd),
        .ref_out   (ref_out),
        .ref_vld   (ref_vld),
        .sync_lost (sync_lost)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // R3 table entry
    function automatic int tbl_of(input int i);
        longint x;
        x = longint'(i) * longint'(256 - i);
        return int'((longint'(32767) * 16 * x) / (longint'(5) * 65536 - 4 * x));
    endfunction

    // R8 clamp
    function automatic int clamp_of(input int c);
        if (c < 0) return 0;
        if (c > 16384) return 16384;
        return c;
    endfunction

    // R9 scaling
    function automatic int ref_of(input int t, input int a);
        longint p;
        p = (longint'(t) * longint'(a) * 48) >>> 18;
        if (p > 32768) p = 32768;
        return int'(p);
    endfunction

    // R6 measurement bounds
    function automatic int meas_of(input int c);
        if (c < 1) return 1;
        if (c > 255) return 255;
        return c;
    endfunction

    task automatic sample(input string req, input bit with_zc);
        int  lim, idx, base, expv;
        bit  bnd, pend;
        pend = 1'b0;
        lim  = (m_state == 2) ? m_per : m_per + m_per / 2;
        bnd  = with_zc || (m_cnt >= lim);
        if (bnd) begin
            m_amp = clamp_of(int'(amp_cmd));
            base  = 0;
        end else begin
            base  = m_phase;
        end
        idx     = base >> 8;
        m_phase = base + m_incr;
        if (m_phase > 65535) m_phase = 65535;
        if (with_zc) begin
            if (m_state == 1) begin
                m_per = meas_of(m_cnt);
                pend  = 1'b1;
            end
            m_state = 1;
        end else if (bnd) begin
            m_state = 2;
        end
        m_cnt = bnd ? 1 : m_cnt + 1;
        expv  = ref_of(tbl_of(idx), m_amp);

        @(negedge clk);
        smp_stb  = 1'b1;
        zc_pulse = with_zc;
        @(negedge clk);
        smp_stb  = 1'b0;
        zc_pulse = 1'b0;
        chk(ref_vld == 1'b0, "R2", "valid one cycle early", ref_vld, 0);
        @(negedge clk);
        chk(ref_vld == 1'b1, "R2", "valid two cycles after strobe", ref_vld, 1);
        chk(ref_out == 16'(expv), req, "reference value", ref_out, expv);
        chk(sync_lost == (m_state == 2), req, "sync_lost flag", sync_lost, (m_state == 2));
        @(negedge clk);
        chk(ref_vld == 1'b0, "R2", "valid lasts one cycle", ref_vld, 0);
        if (pend) m_incr = 65536 / m_per;
        repeat (GAP) @(negedge clk);
    endtask

    task automatic line_zc();
        if (m_state == 1) begin
            m_per  = meas_of(m_cnt);
            m_incr = 65536 / m_per;
        end
        m_state = 1;
        m_phase = 0;
        m_cnt   = 0;
        m_amp   = clamp_of(int'(amp_cmd));
        @(negedge clk);
        zc_pulse = 1'b1;
        @(negedge clk);
        zc_pulse = 1'b0;
        chk(sync_lost == 1'b0, "R13", "pulse clears sync_lost", sync_lost, 0);
        repeat (30) @(negedge clk);
    endtask

    task automatic t_reset();
        m_phase = 0; m_incr = 65536 / 20; m_per = 20; m_cnt = 0; m_state = 0; m_amp = 0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(ref_out == 16'd0, "R1", "reset ref_out", ref_out, 0);
        chk(ref_vld == 1'b0, "R1", "reset ref_vld", ref_vld, 0);
        chk(sync_lost == 1'b0, "R1", "reset sync_lost", sync_lost, 0);
        rst_n = 1'b1;
        @(negedge clk);
        amp_cmd = 16'sd4096;
        sample("R1", 1'b0);
        sample("R1", 1'b0);
    endtask

    task automatic t_lock();
        line_zc();
        for (int k = 0; k < 20; k++) sample("R3", 1'b0);
        line_zc();
        for (int k = 0; k < 25; k++) sample("R4", 1'b0);
        line_zc();
        for (int k = 0; k < 25; k++) sample("R5", 1'b0);
        chk(m_per == 25, "R6", "model period after re-measure", m_per, 25);
    endtask

    task automatic t_amp_latch();
        line_zc();
        for (int k = 0; k < 10; k++) sample("R7", 1'b0);
        amp_cmd = 16'sd16384;
        for (int k = 0; k < 15; k++) sample("R7", 1'b0);
    endtask

    task automatic t_clamp();
        line_zc();
        for (int k = 0; k < 25; k++) sample("R9", 1'b0);
        amp_cmd = -16'sd8192;
        line_zc();
        for (int k = 0; k < 25; k++) sample("R8", 1'b0);
        amp_cmd = 16'sd24576;
        line_zc();
        for (int k = 0; k < 25; k++) sample("R8", 1'b0);
    endtask

    task automatic t_phase_sat();
        amp_cmd = 16'sd4096;
        line_zc();
        for (int k = 0; k < 32; k++) sample("R10", 1'b0);
    endtask

    task automatic t_timeout();
        line_zc();
        for (int k = 0; k < 52; k++) sample("R11", 1'b0);
        chk(sync_lost == 1'b1, "R11", "sync_lost after timeout", sync_lost, 1);
        for (int k = 0; k < 70; k++) sample("R12", 1'b0);
    endtask

    task automatic t_relock();
        line_zc();
        for (int k = 0; k < 10; k++) sample("R13", 1'b0);
        line_zc();
        for (int k = 0; k < 5; k++) sample("R13", 1'b0);
    endtask

    task automatic t_coincident();
        sample("R4", 1'b1);
        for (int k = 0; k < 6; k++) sample("R4", 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_lock();
        t_amp_latch();
        t_clamp();
        t_phase_sat();
        t_timeout();
        t_relock();
        t_coincident();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule